// File: doc/BRIEF.md
# Three-Counter Match Timer

This peripheral holds a set of independent 32-bit up-counters. Each counter has three match comparators, and it sits on a simple single-cycle register bus. Software turns each counter on or off with one enable bit. Each counter runs in one of two modes. In free-running mode it wraps through all 32-bit values. In reload mode a chosen comparator's match loads a preload value back into the counter. A preload selection of zero keeps a counter in reload mode running free.

Each comparator has a sticky status bit. The bit sets when the running counter equals that comparator's value, and software clears it by writing 1. The per-counter interrupt is the registered OR of status AND enable over the three comparators of that counter. Software cannot read a running counter directly. It writes the capture register, which latches the live count. The latched value becomes readable after a settling delay, and a busy flag shows that the delay is still running. Software normally arms a comparator at "captured count + delta", with a delta between 16 and 0xFFFFFFFE ticks.

Register map (word addresses). Page 0: offset 0x0 holds the counter enables (bit n for counter n) and offset 0x1 holds the mode bits (bit n = 1 selects free-running). Counter c uses page c+1, that is address 0x10*(c+1) + offset:

| Offset | Register |
|---|---|
| 0x0–0x2 | match values of comparators 0–2 |
| 0x3 | preload value |
| 0x4 | preload select (2 bits) |
| 0x5 | status (read) |
| 0x6 | write-1 clear |
| 0x7 | interrupt enable |
| 0x8 | capture (any write triggers it, a read returns the latched value) |
| 0x9 | busy flag in bit 0 |

Unmapped addresses read 0.

Top module: `mt_timer_top`

## Requirements
- R1: A counter whose enable bit is 0 keeps its value. With the bit at 1, the counter advances by one on every clock.
- R2: In free-running mode (mode bit 1) the counter steps by one and wraps from 0xFFFFFFFF to 0 without reloading.
- R3: In reload mode (mode bit 0) with preload select k in 1..3, the counter loads the preload value on the clock that follows the cycle in which comparator k-1 matches, instead of incrementing.
- R4: A preload select of 0 leaves a reload-mode counter running free with no reload.
- R5: Status bit k sets on the clock after a cycle in which the enabled counter equals match value k. It stays set until cleared, whatever the interrupt enable is.
- R6: Writing the clear register clears exactly the status bits written as 1. A match in the same cycle wins over the clear.
- R7: The interrupt output of a counter is 1 on the clock after the OR over its comparators of status AND enable was 1. Masking the enable drops the interrupt but keeps the status.
- R8: A write to the capture register latches the live count. For CAP_DELAY cycles after the write the busy flag reads 1 and a capture read returns the previous latched value. After that the new value is returned. A new write restarts the delay.
- R9: A disabled counter sets no status bit, even when its held value equals a match value.
- R10: After reset all counters, registers, status bits, captures and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_wr | input | 1 | write strobe, one write per cycle |
| bus_addr | input | AW | word address |
| bus_wdata | input | CW | write data |
| bus_rdata | output | CW | read data, combinational from bus_addr |
| irq_o | output | N_CNT | per-counter interrupt |

## Verification
Read data follows the address in the same cycle. Status, counter and capture-register changes take effect at the edge that ends the write or match cycle. The interrupt trails the status by one more edge, and a captured value appears CAP_DELAY edges after its write. The reference model advances all of this state at the same edge the design does, and the bench compares both outputs at the following falling edge. Every one of these latencies is therefore checked on every cycle rather than at chosen sample points.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam logic [3:0] GLB_EN   = 4'h0;
  localparam logic [3:0] GLB_MODE = 4'h1;
  localparam logic [3:0] OFS_PRE  = 4'h3;
  localparam logic [3:0] OFS_PLC  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h5;
  localparam logic [3:0] OFS_CLR  = 4'h6;
  localparam logic [3:0] OFS_IE   = 4'h7;
  localparam logic [3:0] OFS_CAP  = 4'h8;
  localparam logic [3:0] OFS_BUSY = 4'h9;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int CW   = 32,
  parameter int NCMP = 3,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            free_i,
  input  logic [SELW-1:0] plsel_i,
  input  logic [CW-1:0]   preload_i,
  input  logic [NCMP-1:0] hit_i,
  output logic [CW-1:0]   cnt_o
);
  logic          reload;
  logic [CW-1:0] cnt_d;

  always_comb begin
    reload = 1'b0;
    for (int k = 0; k < NCMP; k++) begin
      if (!free_i && plsel_i == SELW'(k + 1) && hit_i[k]) reload = 1'b1;
    end
    cnt_d = reload ? preload_i : cnt_o + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_d;
  end

  // R1: disabled counter holds
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_o));
  // R2: free-running step with natural wrap
  p_free_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && free_i) |=> cnt_o == $past(cnt_o) + CW'(1));
  // R4: select 0 never reloads
  p_sel_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && plsel_i == '0) |=> cnt_o == $past(cnt_o) + CW'(1));
endmodule

// File: rtl/mt_match.sv
module mt_match #(
  parameter int CW   = 32,
  parameter int NCMP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic [NCMP*CW-1:0] match_i,
  input  logic [NCMP-1:0]    clr_i,
  input  logic [NCMP-1:0]    ie_i,
  output logic [NCMP-1:0]    hit_o,
  output logic [NCMP-1:0]    stat_o,
  output logic               irq_o
);
  logic [NCMP-1:0] stat_d;
  logic            irq_d;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign hit_o[k] = en_i && (cnt_i == match_i[k*CW +: CW]);
  end

  always_comb begin
    stat_d = (stat_o & ~clr_i) | hit_o;
    irq_d  = |(stat_o & ie_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_o <= stat_d;
      irq_o  <= irq_d;
    end
  end

  // R5: uncleared status stays set
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));
  // R6: a match sets its bit even under a clear
  p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_o) |=> ((stat_o & $past(hit_o)) == $past(hit_o)));
  // R7: no enabled status, no interrupt next cycle
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_o & ie_i)) |=> !irq_o);
endmodule

// File: rtl/mt_capture.sv
module mt_capture #(
  parameter int CW  = 32,
  parameter int DLY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_we_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cap_o,
  output logic          busy_o
);
  localparam int BW = $clog2(DLY + 1);

  logic [BW-1:0] wait_q, wait_d;
  logic [CW-1:0] samp_q, samp_d, cap_d;

  always_comb begin
    cap_d  = (wait_q == BW'(1)) ? samp_q : cap_o;
    samp_d = cap_we_i ? cnt_i : samp_q;
    if (cap_we_i)           wait_d = BW'(DLY);
    else if (wait_q != '0)  wait_d = wait_q - BW'(1);
    else                    wait_d = wait_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      samp_q <= '0;
      cap_o  <= '0;
    end else begin
      wait_q <= wait_d;
      samp_q <= samp_d;
      cap_o  <= cap_d;
    end
  end

  assign busy_o = (wait_q != '0);

  // R8: the visible capture moves only when the delay expires
  p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q != BW'(1)) |=> $stable(cap_o));
  // R8: a capture write makes the block busy
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we_i |=> busy_o);
endmodule

// File: rtl/mt_timer_top.sv
module mt_timer_top import mt_pkg::*; #(
  parameter int N_CNT     = 3,
  parameter int N_CMP     = 3,
  parameter int CW        = 32,
  parameter int AW        = 8,
  parameter int CAP_DELAY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CW-1:0]    bus_wdata,
  output logic [CW-1:0]    bus_rdata,
  output logic [N_CNT-1:0] irq_o
);
  localparam int SELW  = $clog2(N_CMP + 1);
  localparam int PAGEW = AW - 4;

  logic [PAGEW-1:0] page;
  logic [3:0]       ofs;
  logic             glb_w;
  logic [N_CNT-1:0] en_q, en_d, free_q, free_d;
  logic [CW-1:0]    slot_rd [N_CNT];

  assign page  = bus_addr[AW-1:4];
  assign ofs   = bus_addr[3:0];
  assign glb_w = bus_wr && (page == '0);

  always_comb begin
    en_d   = (glb_w && ofs == GLB_EN)   ? bus_wdata[N_CNT-1:0] : en_q;
    free_d = (glb_w && ofs == GLB_MODE) ? bus_wdata[N_CNT-1:0] : free_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      free_q <= '0;
    end else begin
      en_q   <= en_d;
      free_q <= free_d;
    end
  end

  for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
    logic               sel_w;
    logic [N_CMP*CW-1:0] match_q, match_d;
    logic [CW-1:0]      pre_q, pre_d;
    logic [SELW-1:0]    plc_q, plc_d;
    logic [N_CMP-1:0]   ie_q, ie_d, clr, hit, stat;
    logic               cap_we, busy, irq_b;
    logic [CW-1:0]      cnt, capv, rd;

    assign sel_w  = bus_wr && (page == PAGEW'(c + 1));
    assign clr    = (sel_w && ofs == OFS_CLR) ? bus_wdata[N_CMP-1:0] : '0;
    assign cap_we = sel_w && (ofs == OFS_CAP);

    always_comb begin
      match_d = match_q;
      for (int k = 0; k < N_CMP; k++) begin
        if (sel_w && ofs == 4'(k)) match_d[k*CW +: CW] = bus_wdata;
      end
      pre_d = (sel_w && ofs == OFS_PRE) ? bus_wdata            : pre_q;
      plc_d = (sel_w && ofs == OFS_PLC) ? bus_wdata[SELW-1:0]  : plc_q;
      ie_d  = (sel_w && ofs == OFS_IE)  ? bus_wdata[N_CMP-1:0] : ie_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        match_q <= '0;
        pre_q   <= '0;
        plc_q   <= '0;
        ie_q    <= '0;
      end else begin
        match_q <= match_d;
        pre_q   <= pre_d;
        plc_q   <= plc_d;
        ie_q    <= ie_d;
      end
    end

    always_comb begin
      rd = '0;
      for (int k = 0; k < N_CMP; k++) begin
        if (ofs == 4'(k)) rd = match_q[k*CW +: CW];
      end
      case (ofs)
        OFS_PRE:  rd = pre_q;
        OFS_PLC:  rd[SELW-1:0]  = plc_q;
        OFS_STAT: rd[N_CMP-1:0] = stat;
        OFS_IE:   rd[N_CMP-1:0] = ie_q;
        OFS_CAP:  rd = capv;
        OFS_BUSY: rd[0] = busy;
        default:  ;
      endcase
    end
    assign slot_rd[c] = rd;

    mt_match #(.CW(CW), .NCMP(N_CMP)) u_match (
      .clk(clk), .rst_n(rst_n), .en_i(en_q[c]), .cnt_i(cnt),
      .match_i(match_q), .clr_i(clr), .ie_i(ie_q),
      .hit_o(hit), .stat_o(stat), .irq_o(irq_b));

    mt_counter #(.CW(CW), .NCMP(N_CMP), .SELW(SELW)) u_counter (
      .clk(clk), .rst_n(rst_n), .en_i(en_q[c]), .free_i(free_q[c]),
      .plsel_i(plc_q), .preload_i(pre_q), .hit_i(hit), .cnt_o(cnt));

    mt_capture #(.CW(CW), .DLY(CAP_DELAY)) u_capture (
      .clk(clk), .rst_n(rst_n), .cap_we_i(cap_we), .cnt_i(cnt),
      .cap_o(capv), .busy_o(busy));

    assign irq_o[c] = irq_b;

    // R9: a disabled counter raises no new status bit
    p_off_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] |=> ((stat & ~$past(stat)) == '0));
  end

  always_comb begin
    bus_rdata = '0;
    if (page == '0) begin
      if (ofs == GLB_EN)        bus_rdata[N_CNT-1:0] = en_q;
      else if (ofs == GLB_MODE) bus_rdata[N_CNT-1:0] = free_q;
    end else begin
      for (int c = 0; c < N_CNT; c++) begin
        if (page == PAGEW'(c + 1)) bus_rdata = slot_rd[c];
      end
    end
  end
endmodule

// File: tb/mt_timer_top_tb.sv
module mt_timer_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;

  logic        clk, rst_n, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  irq_o;

  mt_timer_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_cmp, n_bad;
  bit    done;
  string cur_req;

  // behavioural reference model
  logic [31:0] m_cnt [3];
  logic [31:0] m_mat [3][3];
  logic [31:0] m_pre [3];
  logic [31:0] m_smp [3];
  logic [31:0] m_cap [3];
  int          m_busy [3];
  logic [1:0]  m_plc [3];
  logic [2:0]  m_st [3];
  logic [2:0]  m_ie [3];
  logic [2:0]  m_en, m_free, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_free = 0; m_irq = 0;
      for (int c = 0; c < 3; c++) begin
        m_cnt[c] = 0; m_pre[c] = 0; m_smp[c] = 0; m_cap[c] = 0;
        m_busy[c] = 0; m_plc[c] = 0; m_st[c] = 0; m_ie[c] = 0;
        for (int k = 0; k < 3; k++) m_mat[c][k] = 0;
      end
    end else begin
      automatic int pg = int'(bus_addr[7:4]);
      automatic int of = int'(bus_addr[3:0]);
      for (int c = 0; c < 3; c++) begin
        automatic bit w = bus_wr && pg == c + 1;
        automatic logic [2:0] hit = 0;
        automatic logic [2:0] clr = 0;
        automatic logic [31:0] old = m_cnt[c];
        for (int k = 0; k < 3; k++) hit[k] = m_en[c] && old == m_mat[c][k];
        m_irq[c] = |(m_st[c] & m_ie[c]);
        if (w && of == 6) clr = bus_wdata[2:0];
        m_st[c] = (m_st[c] & ~clr) | hit;
        if (m_en[c]) begin
          if (!m_free[c] && m_plc[c] != 0 && hit[m_plc[c] - 1]) m_cnt[c] = m_pre[c];
          else m_cnt[c] = old + 1;
        end
        if (m_busy[c] == 1) m_cap[c] = m_smp[c];
        if (w && of == 8) begin m_busy[c] = DLY; m_smp[c] = old; end
        else if (m_busy[c] > 0) m_busy[c]--;
        if (w && of < 3) m_mat[c][of] = bus_wdata;
        if (w && of == 3) m_pre[c] = bus_wdata;
        if (w && of == 4) m_plc[c] = bus_wdata[1:0];
        if (w && of == 7) m_ie[c] = bus_wdata[2:0];
      end
      if (bus_wr && pg == 0 && of == 0) m_en = bus_wdata[2:0];
      if (bus_wr && pg == 0 && of == 1) m_free = bus_wdata[2:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    automatic int pg = int'(a[7:4]);
    automatic int of = int'(a[3:0]);
    logic [31:0] r = 0;
    if (pg == 0) begin
      if (of == 0) r = {29'b0, m_en};
      else if (of == 1) r = {29'b0, m_free};
    end else if (pg <= 3) begin
      automatic int c = pg - 1;
      case (of)
        0, 1, 2: r = m_mat[c][of];
        3: r = m_pre[c];
        4: r = {30'b0, m_plc[c]};
        5: r = {29'b0, m_st[c]};
        7: r = {29'b0, m_ie[c]};
        8: r = m_cap[c];
        9: r = {31'b0, m_busy[c] != 0};
        default: r = 0;
      endcase
    end
    return r;
  endfunction

  // compare on every falling edge, inputs change 1 time unit later
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (irq_o !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq: actual %b expected %b", cur_req, irq_o, m_irq);
      end
      n_cmp++;
      if (bus_rdata !== m_read(bus_addr)) begin
        n_bad++;
        $display("FAIL %s rdata @%h: actual %h expected %h", cur_req, bus_addr,
                 bus_rdata, m_read(bus_addr));
      end
    end
  end

  function automatic logic [7:0] ra(input int c, input int o);
    return 8'((c + 1) * 16 + o);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic look(input logic [7:0] a, input int n);
    @(negedge clk); #1;
    bus_addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic cap_and_read(input int c);
    wr(ra(c, 8), 32'h0);
    look(ra(c, 9), 2);
    look(ra(c, 8), DLY + 1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    cur_req = "R10";
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    look(8'h00, 2);
    look(ra(0, 5), 2);
    look(ra(1, 8), 2);

    cur_req = "R2";
    wr(8'h01, 32'h1);
    wr(ra(0, 0), 32'd20);
    wr(ra(0, 7), 32'h1);
    cur_req = "R1";
    wr(8'h00, 32'h1);
    cur_req = "R5";
    look(ra(0, 5), 30);
    cur_req = "R8";
    cap_and_read(0);
    wr(ra(0, 8), 32'h0);
    wr(ra(0, 8), 32'h0);
    look(ra(0, 8), DLY + 2);

    cur_req = "R6";
    wr(ra(0, 6), 32'h1);
    look(ra(0, 5), 3);
    wr(ra(0, 1), m_cnt[0] + 10);
    wr(ra(0, 2), m_cnt[0] + 12);
    wr(ra(0, 7), 32'h6);
    look(ra(0, 5), 16);
    wr(ra(0, 6), 32'h2);
    look(ra(0, 5), 3);
    cur_req = "R7";
    wr(ra(0, 7), 32'h0);
    look(ra(0, 5), 3);
    wr(ra(0, 7), 32'h4);
    look(ra(0, 5), 3);
    cur_req = "R6";
    wr(ra(0, 6), 32'h7);
    look(ra(0, 5), 3);

    cur_req = "R3";
    wr(ra(1, 1), 32'd9);
    wr(ra(1, 3), 32'd3);
    wr(ra(1, 4), 32'd2);
    wr(ra(1, 7), 32'h7);
    wr(8'h00, 32'h3);
    for (int i = 0; i < 6; i++) cap_and_read(1);
    cur_req = "R4";
    wr(ra(1, 4), 32'd0);
    for (int i = 0; i < 4; i++) cap_and_read(1);

    cur_req = "R2";
    wr(ra(2, 0), 32'd5);
    wr(ra(2, 3), 32'hFFFF_FFF8);
    wr(ra(2, 4), 32'd1);
    wr(8'h00, 32'h7);
    look(ra(2, 5), 8);
    wr(8'h01, 32'h5);
    wr(ra(2, 1), 32'd2);
    wr(ra(2, 7), 32'h2);
    look(ra(2, 5), 20);
    cap_and_read(2);

    cur_req = "R9";
    wr(8'h00, 32'h6);
    wr(ra(0, 2), m_cnt[0]);
    wr(ra(0, 6), 32'h7);
    look(ra(0, 5), 6);
    cur_req = "R1";
    cap_and_read(0);
    cap_and_read(0);

    finish_run();
  end
endmodule